// File: doc/BRIEF.md
# Setup command capture buffer

This block holds the most recent setup command that arrives on a USB control endpoint, in an eight-byte store. The USB side gives a start-of-setup pulse, then a stream of bytes, then an end pulse marked good or bad. A good end raises a setup-received flag for the CPU. The CPU reads the command one byte at a time. A read pointer advances on each read, and the CPU clears the flag when it is done.

Reception is never refused. A new setup overwrites any command that has not been read yet. If it begins while the CPU is part-way through a read, the read is cut off, the read pointer returns to byte 0, and a read-invalid status tells software that the bytes it already took are not to be trusted. The read-invalid status stays set until the CPU clears the setup-received flag.

Top module: `setup_capture_buf`

## Requirements
- R1: After reset, setup_flag is 0 and rd_invalid is 0.
- R2: After a start pulse, the bytes strobed in by usb_byte_valid are stored at positions 0 to 7 in arrival order. Bytes past the eighth are dropped. The start cycle itself stores no byte.
- R3: A usb_end pulse with usb_end_good=1, and no start in the same cycle, sets setup_flag on the next clock edge.
- R4: A usb_end pulse with usb_end_good=0 leaves setup_flag at 0. The stored contents are then unspecified.
- R5: A start pulse clears setup_flag and returns the read pointer to byte 0. The next command replaces unread contents, and reads return the new bytes.
- R6: A start pulse that arrives while a read is in progress sets rd_invalid and moves the read pointer to byte 0. A read is in progress when the pointer is not at 0, or when cpu_rd_en is high in the same cycle.
- R7: cpu_rd_data presents, without delay, the byte at the read pointer. Each cycle with cpu_rd_en high advances the pointer by one.
- R8: With the pointer past byte 7, cpu_rd_data is 0 and further reads leave the pointer where it is, with no wrap.
- R9: cpu_flag_clr clears setup_flag and rd_invalid and returns the read pointer to byte 0.
- R10: When cpu_flag_clr coincides with a good end, setup_flag stays set and the clear has no effect.
- R11: A start pulse with the pointer at 0 and no read in the same cycle leaves rd_invalid unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usb_setup_start | input | 1 | Pulse: a setup reception begins |
| usb_byte_valid | input | 1 | Strobe for usb_byte |
| usb_byte | input | 8 | Received setup byte |
| usb_end | input | 1 | Pulse: the setup reception has ended |
| usb_end_good | input | 1 | Qualifies usb_end: 1 for error-free, 0 for error |
| cpu_rd_en | input | 1 | Consume the current byte and advance the pointer |
| cpu_rd_data | output | 8 | Byte at the read pointer, or 0 past the end |
| cpu_flag_clr | input | 1 | CPU writes 0 to the setup-received flag |
| setup_flag | output | 1 | A good setup command is held |
| rd_invalid | output | 1 | A read was cut off by a new setup |

## Verification
setup_flag and rd_invalid are registered, so they change one clock edge after the input cycle that causes the change. cpu_rd_data follows the read pointer through combinational logic, so a new byte appears in the same edge that moves the pointer. The bench drives each input cycle at a falling edge and updates its reference model right after the rising edge. It then compares all three outputs at the following falling edge, which is exactly one register stage after the stimulus. Bytes that have never been written are marked unknown in the model, and the data comparison is skipped for them.

// File: rtl/scb_pkg.sv
package scb_pkg;
  localparam int unsigned SCB_DEPTH = 8;
  localparam int unsigned SCB_DW    = 8;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_e;
endpackage

// File: rtl/scb_store.sv
module scb_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 8,
  parameter int unsigned PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [DW-1:0]    wr_data,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic [DW-1:0]    rd_data
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] FULL = PTR_W'(DEPTH);

  logic [DW-1:0] lane_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_lane
    logic          lane_we;
    logic [DW-1:0] lane_q;
    assign lane_we = wr_en && (wr_ptr == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (lane_we) lane_q <= wr_data;
    end
    assign lane_w[g] = lane_q;
  end

  always_comb begin
    rd_data = '0;
    if (rd_ptr < FULL) rd_data = lane_w[rd_ptr[IDX_W-1:0]];
  end

  // R2: a written byte lands in the lane picked by the write pointer
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ptr < FULL) |=> lane_w[$past(wr_ptr[IDX_W-1:0])] == $past(wr_data));
endmodule

// File: rtl/scb_wr_ctrl.sv
module scb_wr_ctrl
  import scb_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_start,
  input  logic             rx_we,
  input  logic             rx_end,
  input  logic             rx_ok,
  input  logic             cpu_clr,
  output logic             mem_we,
  output logic [PTR_W-1:0] wr_ptr,
  output logic             flag,
  output logic             clr_eff
);
  localparam logic [PTR_W-1:0] FULL = PTR_W'(DEPTH);

  rx_state_e        state_q, state_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             flag_q, flag_d;
  logic             state_en, ptr_en, flag_en;
  logic             good_end;

  always_comb begin
    good_end = rx_end && rx_ok && !rx_start;
    clr_eff  = cpu_clr && !good_end;
    mem_we   = rx_we && !rx_start && (state_q == RX_BUSY) && (ptr_q < FULL);

    state_en = rx_start || rx_end;
    state_d  = rx_start ? RX_BUSY : RX_IDLE;

    ptr_en   = rx_start || mem_we;
    ptr_d    = rx_start ? '0 : ptr_q + 1'b1;

    flag_en  = rx_start || good_end || clr_eff;
    flag_d   = good_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      ptr_q   <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (state_en) state_q <= state_d;
      if (ptr_en)   ptr_q   <= ptr_d;
      if (flag_en)  flag_q  <= flag_d;
    end
  end

  assign wr_ptr = ptr_q;
  assign flag   = flag_q;

  // R3: error-free end raises the flag
  assert_good_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_end && rx_ok && !rx_start) |=> flag);
  // R4: erroneous end never raises the flag
  assert_err_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_end && !rx_ok && !flag) |=> !flag);
  // R5: a start drops the flag and rewinds the write side
  assert_start_rewind_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start |=> (!flag && wr_ptr == '0));
  // R10: a clear coinciding with a good end is lost
  assert_clr_loses_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clr && rx_end && rx_ok && !rx_start) |=> flag);
  // R2: the write pointer never runs past the store
  assert_wr_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr <= FULL);
endmodule

// File: rtl/scb_rd_ctrl.sv
module scb_rd_ctrl #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_start,
  input  logic             rd_en,
  input  logic             clr_eff,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             rd_invalid
);
  localparam logic [PTR_W-1:0] FULL = PTR_W'(DEPTH);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             inv_q, inv_d;
  logic             ptr_en, inv_en, abort, advance;

  always_comb begin
    abort   = rx_start && ((ptr_q != '0) || rd_en);
    advance = rd_en && (ptr_q < FULL);

    ptr_en  = rx_start || clr_eff || advance;
    ptr_d   = (rx_start || clr_eff) ? '0 : ptr_q + 1'b1;

    inv_en  = abort || clr_eff;
    inv_d   = abort;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      inv_q <= 1'b0;
    end else begin
      if (ptr_en) ptr_q <= ptr_d;
      if (inv_en) inv_q <= inv_d;
    end
  end

  assign rd_ptr     = ptr_q;
  assign rd_invalid = inv_q;

  // R6: a start during a read marks it invalid and rewinds
  assert_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_start && rd_ptr != '0) |=> (rd_invalid && rd_ptr == '0));
  // R8: no wrap past the end
  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ptr == FULL && !rx_start && !clr_eff) |=> rd_ptr == FULL);
  // R9: the clear drops the invalid status and rewinds
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_eff && !rx_start) |=> (!rd_invalid && rd_ptr == '0));
  // R11: a start with no read in progress leaves the status alone
  assert_no_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_start && rd_ptr == '0 && !rd_en && !rd_invalid && !clr_eff) |=> !rd_invalid);
endmodule

// File: rtl/setup_capture_buf.sv
module setup_capture_buf
  import scb_pkg::*;
#(
  parameter int unsigned DEPTH = SCB_DEPTH,
  parameter int unsigned DW    = SCB_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          usb_setup_start,
  input  logic          usb_byte_valid,
  input  logic [DW-1:0] usb_byte,
  input  logic          usb_end,
  input  logic          usb_end_good,
  input  logic          cpu_rd_en,
  output logic [DW-1:0] cpu_rd_data,
  input  logic          cpu_flag_clr,
  output logic          setup_flag,
  output logic          rd_invalid
);
  localparam int unsigned PTR_W = $clog2(DEPTH + 1);

  logic             mem_we, clr_eff;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  scb_wr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .rx_start(usb_setup_start), .rx_we(usb_byte_valid),
    .rx_end(usb_end), .rx_ok(usb_end_good), .cpu_clr(cpu_flag_clr),
    .mem_we(mem_we), .wr_ptr(wr_ptr), .flag(setup_flag), .clr_eff(clr_eff)
  );

  scb_rd_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rx_start(usb_setup_start), .rd_en(cpu_rd_en),
    .clr_eff(clr_eff), .rd_ptr(rd_ptr), .rd_invalid(rd_invalid)
  );

  scb_store #(.DEPTH(DEPTH), .DW(DW), .PTR_W(PTR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(mem_we), .wr_ptr(wr_ptr), .wr_data(usb_byte),
    .rd_ptr(rd_ptr), .rd_data(cpu_rd_data)
  );

  // R1: both status outputs are low out of reset
  assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!setup_flag && !rd_invalid));
endmodule

// File: tb/test_setup_capture_buf.sv
`timescale 1ns/1ps
module test_setup_capture_buf;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s = 1'b0, w = 1'b0, e = 1'b0, ok = 1'b0, r = 1'b0, c = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rd_data;
  logic       flag, inv;

  always #2 clk = ~clk;

  setup_capture_buf i_setup_capture_buf (
    .clk(clk), .rst_n(rst_n), .usb_setup_start(s), .usb_byte_valid(w), .usb_byte(wd),
    .usb_end(e), .usb_end_good(ok), .cpu_rd_en(r), .cpu_rd_data(rd_data),
    .cpu_flag_clr(c), .setup_flag(flag), .rd_invalid(inv)
  );

  int checks = 0, fails = 0;
  string req = "R1";

  int m_mem[8];
  int m_wp = 0, m_rp = 0;
  bit m_flag = 0, m_inv = 0, m_busy = 0;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    int exp_d;
    chk("setup_flag", int'(flag), int'(m_flag));
    chk("rd_invalid", int'(inv), int'(m_inv));
    exp_d = (m_rp < 8) ? m_mem[m_rp] : 0;
    if (exp_d >= 0) chk("cpu_rd_data", int'(rd_data), exp_d);
  endtask

  task automatic model_step();
    bit good, abort, clr;
    good  = e && ok && !s;
    abort = s && (m_rp != 0 || r);
    clr   = c && !good;
    if (s) begin
      m_wp = 0; m_flag = 0; m_rp = 0; m_busy = 1;
    end else begin
      if (w && m_busy && m_wp < 8) begin
        m_mem[m_wp] = int'(wd);
        m_wp++;
      end
      if (e) m_busy = 0;
      if (good) m_flag = 1;
      else if (clr) m_flag = 0;
      if (clr) m_rp = 0;
      else if (r && m_rp < 8) m_rp++;
    end
    if (abort) m_inv = 1;
    else if (clr) m_inv = 0;
  endtask

  task automatic cyc(bit is, bit iw, logic [7:0] iwd, bit ie, bit iok, bit ir, bit ic);
    s = is; w = iw; wd = iwd; e = ie; ok = iok; r = ir; c = ic;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    cyc(0, 0, 8'h00, 0, 0, 0, 0);
  endtask

  task automatic send(int n, int base, bit good);
    cyc(1, 0, 8'h00, 0, 0, 0, 0);
    for (int i = 0; i < n; i++) cyc(0, 1, 8'(base + 7 * i), 0, 0, 0, 0);
    cyc(0, 0, 8'h00, 1, good, 0, 0);
  endtask

  task automatic rd(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 0, 0, 1, 0);
  endtask

  task automatic clear();
    cyc(0, 0, 8'h00, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (25000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_mem[i] = -1;
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("setup_flag", int'(flag), 0);
    chk("rd_invalid", int'(inv), 0);
    rst_n = 1'b1;
    idle();

    // R2 R3 R7: full packet then read it out in order
    req = "R3"; send(8, 8'h11, 1);
    req = "R7"; rd(8);
    // R8: past the end reads 0 and holds
    req = "R8"; rd(3);
    // R9: clear the flag
    req = "R9"; clear(); idle();

    // R2: ten bytes, only eight kept
    req = "R2"; send(10, 8'h40, 1); rd(9); clear();

    // R4: error end leaves the flag clear
    req = "R4"; send(5, 8'h90, 0); idle(); idle();

    // R5: unread command replaced by a newer one
    req = "R5"; send(8, 8'h20, 1); rd(2); clear();
    send(8, 8'h21, 1); send(8, 8'hA3, 1); rd(8); clear();

    // R6: start in the middle of a read
    req = "R6"; send(8, 8'h05, 1); rd(3);
    send(8, 8'h66, 1); rd(4); idle();
    req = "R9"; clear(); idle();
    // R6: start in the same cycle as the first read
    req = "R6"; cyc(1, 0, 8'h00, 0, 0, 1, 0);
    for (int i = 0; i < 8; i++) cyc(0, 1, 8'(8'hC0 + i), 0, 0, 0, 0);
    cyc(0, 0, 8'h00, 1, 1, 0, 0); rd(2); clear();

    // R10: clear coinciding with a good end
    req = "R10"; cyc(1, 0, 8'h00, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) cyc(0, 1, 8'(8'h70 + i), 0, 0, 0, 0);
    cyc(0, 0, 8'h00, 1, 1, 0, 1); idle(); rd(1);

    // R11: start with no read in progress keeps status low
    req = "R11"; clear(); send(8, 8'h33, 1); idle(); rd(8); clear(); idle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule